// File: doc/BRIEF.md
# Serial Word Loader

This block gathers words from a bit-serial line and hands each completed word to a downstream fall-through stack. It runs on one system clock. It samples the serial clock, the serial data and an active-low serial enable through a synchronizer. On every detected high-to-low transition of the serial clock it shifts one bit into a shift register, as long as the enable is low. Once the last bit of a word is in, an active-low full flag drops.

A word leaves the block when three things hold at once: the active-low transfer request is low, the downstream stack reports an empty top slot, and the word has not already been moved. The block then raises a push strobe for one cycle with the word beside it and clears its shift register, so the next word can be collected. A set/reset latch remembers that the transfer took place. While the request stays low, no second push can happen, even if another word fills up in the meantime. The latch is released when the request goes high. Wiring the full flag straight back to the request input therefore pushes every word exactly once, with no further logic.

Top module: `serial_word_loader`

## Requirements
- R1: While the serial enable is low, each falling edge of the serial clock shifts the serial data bit into the word. The first bit of a word ends up in the most significant bit (word[3]) and the last bit in word[0].
- R2: A word is 4 bits wide. The full flag is low exactly when 4 bits have been collected, and high while fewer than 4 bits are present.
- R3: Falling edges of the serial clock that occur while the serial enable is high change neither the word nor the bit count.
- R4: While the full flag is low, further serial clock edges are ignored and the word holds its value until it is transferred.
- R5: A transfer takes place only when the word is full, the transfer request is low and the top-slot-empty input is high. When any of these is missing, no push occurs and the word is held.
- R6: A transfer produces a push strobe that is high for exactly one clock cycle, with push_word equal to the collected word.
- R7: In the cycle the push strobe is high, the register has already been cleared: word is 0 and the full flag is high.
- R8: While the transfer request stays low, at most one push occurs. A later full word waits until the request has returned high and then gone low again.
- R9: When the full flag is fed back as the transfer request, every collected word is pushed exactly once and in order.
- R10: A low master reset clears the bit count, the word, the full flag, the push strobe and the transfer latch. This includes a partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mr_n | input | 1 | Master reset, active low, synchronous |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial clock; a bit is taken on its falling edge |
| ser_en_n | input | 1 | Serial enable, active low |
| xfer_req_n | input | 1 | Transfer request, active low |
| top_empty | input | 1 | Downstream top slot is empty |
| word | output | 4 | Shift register contents |
| full_n | output | 1 | Register full, active low |
| push | output | 1 | One-cycle push strobe to the stack |
| push_word | output | 4 | Word carried by the push strobe |

## Verification
Every one of the 16 possible words is shifted in. This checks that the bit order is right and that no bit position is stuck or swapped, and each word is then pushed so that push_word is compared against the same value. For each word the bench also sends an extra clock once the register is full, withholds the top-slot signal, and then grants it. These three steps separate ignoring clocks while full, waiting for room, and the clear after a push. Further patterns cover:
- clocks sent while the serial enable is high;
- a request held low across two words, which tells the one-shot latch apart from simple level-triggered pushing;
- a run in which full_n is fed back as the request;
- a reset in the middle of a word.

// File: rtl/serial_word_loader_pkg.sv
package serial_word_loader_pkg;

   typedef struct packed {
      logic sclk;
      logic sdata;
      logic sen_n;
   } ser_bits_t;

   localparam ser_bits_t SER_IDLE = '{sclk: 1'b0, sdata: 1'b0, sen_n: 1'b1};

endpackage

// File: rtl/swl_edge_sync.sv
module swl_edge_sync
   import serial_word_loader_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  ser_bits_t raw,
   output ser_bits_t synced,
   output logic      sclk_fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("swl_edge_sync: STAGES must be at least 2");
   end

   ser_bits_t pipe [STAGES];
   logic      prev_sclk;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) pipe[0] <= SER_IDLE;
            else        pipe[0] <= raw;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) pipe[i] <= SER_IDLE;
            else        pipe[i] <= pipe[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_sclk <= 1'b0;
      else        prev_sclk <= pipe[STAGES-1].sclk;
   end

   assign synced    = pipe[STAGES-1];
   assign sclk_fall = prev_sclk & ~pipe[STAGES-1].sclk;

endmodule

// File: rtl/swl_shifter.sv
module swl_shifter #(
   parameter int WORD_W    = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   input  logic              clear,
   output logic [WORD_W-1:0] word,
   output logic              full
);

   localparam int CNT_W = $clog2(WORD_W + 1);

   if (WORD_W < 2) begin : g_bad_width
      $error("swl_shifter: WORD_W must be at least 2");
   end

   logic [CNT_W-1:0]  count;
   logic [WORD_W-1:0] shifted;

   if (MSB_FIRST) begin : g_msb_first
      assign shifted = {word[WORD_W-2:0], bit_in};
   end else begin : g_lsb_first
      assign shifted = {bit_in, word[WORD_W-1:1]};
   end

   assign full = (count == CNT_W'(WORD_W));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         count <= '0;
         word  <= '0;
      end else if (shift_en && !full) begin
         count <= count + CNT_W'(1);
         word  <= shifted;
      end
   end

endmodule

// File: rtl/swl_xfer_ctl.sv
module swl_xfer_ctl #(
   parameter int WORD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              full,
   input  logic              xfer_req_n,
   input  logic              top_empty,
   input  logic [WORD_W-1:0] word,
   output logic              fire,
   output logic              push,
   output logic [WORD_W-1:0] push_word
);

   logic moved;

   assign fire = full && !xfer_req_n && top_empty && !moved;

   always_ff @(posedge clk) begin
      if (!rst_n)          moved <= 1'b0;
      else if (fire)       moved <= 1'b1;
      else if (xfer_req_n) moved <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         push      <= 1'b0;
         push_word <= '0;
      end else begin
         push <= fire;
         if (fire) push_word <= word;
      end
   end

endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader
   import serial_word_loader_pkg::*;
#(
   parameter int WORD_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              mr_n,
   input  logic              ser_data,
   input  logic              ser_clk,
   input  logic              ser_en_n,
   input  logic              xfer_req_n,
   input  logic              top_empty,
   output logic [WORD_W-1:0] word,
   output logic              full_n,
   output logic              push,
   output logic [WORD_W-1:0] push_word
);

   ser_bits_t raw_bits;
   ser_bits_t sync_bits;
   logic      sclk_fall;
   logic      full;
   logic      fire;

   assign raw_bits = '{sclk: ser_clk, sdata: ser_data, sen_n: ser_en_n};

   swl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (mr_n),
      .raw       (raw_bits),
      .synced    (sync_bits),
      .sclk_fall (sclk_fall)
   );

   swl_shifter #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk      (clk),
      .rst_n    (mr_n),
      .shift_en (sclk_fall && !sync_bits.sen_n),
      .bit_in   (sync_bits.sdata),
      .clear    (fire),
      .word     (word),
      .full     (full)
   );

   swl_xfer_ctl #(.WORD_W(WORD_W)) u_xfer (
      .clk        (clk),
      .rst_n      (mr_n),
      .full       (full),
      .xfer_req_n (xfer_req_n),
      .top_empty  (top_empty),
      .word       (word),
      .fire       (fire),
      .push       (push),
      .push_word  (push_word)
   );

   assign full_n = ~full;

endmodule

// File: rtl/serial_word_loader_chk.sv
module serial_word_loader_chk #(
   parameter int WORD_W = 4
) (
   input logic              clk,
   input logic              mr_n,
   input logic              xfer_req_n,
   input logic              top_empty,
   input logic [WORD_W-1:0] word,
   input logic              full_n,
   input logic              push
);

   AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!mr_n)
      push |=> !push); // R6

   AST_PUSH_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!mr_n)
      push |-> ($past(top_empty) && !$past(xfer_req_n) && !$past(full_n))); // R5

   AST_CLEARED_ON_PUSH: assert property (@(posedge clk) disable iff (!mr_n)
      push |-> (full_n && word == '0)); // R7

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!mr_n)
      (!full_n && (xfer_req_n || !top_empty)) |=> !full_n); // R4

   AST_WORD_HELD_WHEN_FULL: assert property (@(posedge clk) disable iff (!mr_n)
      !full_n |=> (push || $stable(word))); // R4

endmodule

bind serial_word_loader serial_word_loader_chk #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .mr_n       (mr_n),
   .xfer_req_n (xfer_req_n),
   .top_empty  (top_empty),
   .word       (word),
   .full_n     (full_n),
   .push       (push)
);

// File: tb/serial_word_loader_test.sv
`timescale 1ns/1ps
module serial_word_loader_test;

   logic       clk = 1'b0;
   logic       mr_n = 1'b0;
   logic       ser_data = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_en_n = 1'b1;
   logic       xfer_man_n = 1'b1;
   logic       auto_mode = 1'b0;
   logic       top_empty = 1'b0;
   logic       xfer_req_n;
   logic [3:0] word;
   logic       full_n;
   logic       push;
   logic [3:0] push_word;

   int n_checks = 0;
   int n_fail = 0;
   int push_cnt = 0;
   logic [3:0] last_push;
   logic [3:0] auto_log [4];

   always #4 clk = ~clk;

   assign xfer_req_n = auto_mode ? full_n : xfer_man_n;

   serial_word_loader uut (
      .clk(clk), .mr_n(mr_n), .ser_data(ser_data), .ser_clk(ser_clk),
      .ser_en_n(ser_en_n), .xfer_req_n(xfer_req_n), .top_empty(top_empty),
      .word(word), .full_n(full_n), .push(push), .push_word(push_word)
   );

   always @(negedge clk) begin
      if (push) begin
         if (push_cnt < 4) auto_log[push_cnt] = push_word;
         push_cnt++;
         last_push = push_word;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      ser_data = b;
      ser_clk  = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk  = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_word(input logic [3:0] v);
      for (int b = 3; b >= 0; b--) send_bit(v[b]);
   endtask

   task automatic do_reset();
      mr_n = 1'b0;
      repeat (3) @(negedge clk);
      mr_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      int base;
      do_reset();
      chk("R10 reset word", word, 0);
      chk("R10 reset full_n", full_n, 1);
      chk("R10 reset push", push, 0);

      ser_en_n = 1'b0;
      for (int v = 0; v < 16; v++) begin
         for (int b = 3; b >= 1; b--) send_bit(v[b]);
         chk("R2 three bits not full", full_n, 1);
         send_bit(v[0]);
         chk("R2 full after four", full_n, 0);
         chk("R1 word order", word, v);
         send_bit(~v[0]);
         chk("R4 extra clock ignored", word, v);
         base = push_cnt;
         xfer_man_n = 1'b0;
         top_empty  = 1'b0;
         repeat (6) @(negedge clk);
         chk("R5 no room no push", push_cnt - base, 0);
         chk("R5 word held", word, v);
         top_empty = 1'b1;
         repeat (6) @(negedge clk);
         chk("R6 single push", push_cnt - base, 1);
         chk("R6 push_word", last_push, v);
         chk("R7 cleared word", word, 0);
         chk("R7 full_n released", full_n, 1);
         xfer_man_n = 1'b1;
         top_empty  = 1'b0;
         @(negedge clk);
      end

      ser_en_n = 1'b1;
      send_word(4'hF);
      chk("R3 disabled word", word, 0);
      chk("R3 disabled full_n", full_n, 1);
      ser_en_n = 1'b0;

      top_empty  = 1'b1;
      xfer_man_n = 1'b0;
      base = push_cnt;
      send_word(4'hA);
      repeat (3) @(negedge clk);
      chk("R8 first push", push_cnt - base, 1);
      send_word(4'h5);
      repeat (6) @(negedge clk);
      chk("R8 held request no second push", push_cnt - base, 1);
      chk("R8 second word waits", full_n, 0);
      xfer_man_n = 1'b1;
      @(negedge clk);
      xfer_man_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 push after re-request", push_cnt - base, 2);
      chk("R8 second push_word", last_push, 5);
      xfer_man_n = 1'b1;
      @(negedge clk);

      auto_mode = 1'b1;
      base = push_cnt;
      send_word(4'h3);
      send_word(4'hC);
      send_word(4'h9);
      repeat (3) @(negedge clk);
      chk("R9 auto push count", push_cnt - base, 3);
      if (base + 3 <= 4) chk("R9 auto order", auto_log[base], 3);
      chk("R9 auto last word", last_push, 9);
      chk("R9 auto ends empty", full_n, 1);
      auto_mode = 1'b0;

      send_bit(1'b1);
      send_bit(1'b1);
      do_reset();
      chk("R10 partial cleared", word, 0);
      send_word(4'h6);
      chk("R10 count restarted", full_n, 0);
      chk("R10 word after reset", word, 6);

      xfer_man_n = 1'b0;
      top_empty  = 1'b1;
      repeat (3) @(negedge clk);
      base = push_cnt;
      chk("R10 pushed after reset", last_push, 6);
      send_word(4'h2);
      do_reset();
      send_word(4'hE);
      repeat (3) @(negedge clk);
      chk("R10 latch cleared by reset", push_cnt - base, 1);
      chk("R10 push_word after latch clear", last_push, 14);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule